// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Acknowledge

This block gathers interrupt requests from a row of device slots onto one shared request line. It resolves the processor's answer on a single acknowledge line that runs through the slots in order. Each slot keeps a pending flag and a programmable vector number. When the processor raises acknowledge, the signal enters slot 0 and moves away from the processor. A slot that holds a claim keeps the acknowledge for itself and blocks every slot after it. A slot with no claim passes the acknowledge on to the next slot.

The winning slot places its own vector number on the vector bus, together with a valid strobe, for as long as acknowledge stays high. The processor therefore learns the source directly and does not poll the devices. The winner is locked in on the first acknowledged cycle, so a request that arrives later cannot take the acknowledge away from it. When acknowledge drops, the served slot clears its own pending flag. The acknowledge that leaves the last slot is brought out, so the processor can see that nobody answered.

Top module: `vecack_chain`

## Requirements
- R1: After reset no slot is pending, `irq_out`, `vec_valid` and `ack_tail` are 0, `vec_out` is 0, and the vector register of slot i holds `RST_VEC_BASE + i` (default 0x40 + i).
- R2: A 1 on bit i of `req_set` at a clock edge makes slot i pending. `irq_out` is 1 exactly when at least one slot is pending.
- R3: While `iack_in` is 1, the pending slot with the lowest index wins, because slot 0 sits nearest the processor. In the same cycle `vec_out` shows that slot's vector register and `vec_valid` is 1.
- R4: `vec_out` is 0 and `vec_valid` is 0 whenever `iack_in` is 0, or when no slot claims the acknowledge.
- R5: `ack_tail` is 1 exactly when `iack_in` is 1 and no slot claims the acknowledge.
- R6: At the first clock edge where `iack_in` is 0 after a slot has won, that slot's pending flag is cleared. Other pending flags are left unchanged.
- R7: A request that becomes pending while a winner already holds the acknowledge does not change the winner until `iack_in` falls. The new request is kept for a later acknowledge.
- R8: With `cfg_we` at 1, the clock edge loads `cfg_vec` into the vector register of the slot whose index is `cfg_sel`. The other slots keep their vectors.
- R9: If a new request for the winning slot arrives on the same edge that would clear that slot, the slot stays pending.
- R10: While `iack_in` stays high over several cycles, `vec_out` and `vec_valid` stay constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_set | input | N_SLOTS | Per-slot request pulse; sets the pending flag |
| cfg_we | input | 1 | Vector register write enable |
| cfg_sel | input | SEL_W | Index of the slot to program |
| cfg_vec | input | VEC_W | Vector value to write |
| iack_in | input | 1 | Acknowledge from the processor, enters slot 0 |
| irq_out | output | 1 | Shared request line (OR of pending flags) |
| vec_out | output | VEC_W | Vector number supplied by the winning slot |
| vec_valid | output | 1 | High while a slot supplies its vector |
| ack_tail | output | 1 | Acknowledge leaving the last slot |

## Verification
The bench tries every non-empty set of pending slots. It drains each set one acknowledge at a time and expects the winners in ascending index order. A chain built in the wrong direction, or one that lets the acknowledge pass a claiming slot, would give the wrong vector or a second valid source. The bench raises a request nearer the processor in the middle of an acknowledge. A design that re-arbitrates every cycle would switch vectors halfway through the handshake. The bench also sets a request on the same edge as the self-clear, which a clear-over-set priority would lose. Finally it checks an acknowledge with nothing pending, where the tail must go high and the vector bus must stay 0.

// File: rtl/vecack_pkg.sv
package vecack_pkg;
  localparam int unsigned DEF_SLOTS = 4;
  localparam int unsigned DEF_VEC_W = 8;

  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/vecack_slot.sv
module vecack_slot #(
  parameter int unsigned VEC_W   = 8,
  parameter logic [VEC_W-1:0] RST_VEC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             hold_i,
  input  logic             won_i,
  input  logic             cfg_we_i,
  input  logic [VEC_W-1:0] cfg_vec_i,
  input  logic             ack_in,
  output logic             ack_out,
  output logic             grant_o,
  output logic             pend_o,
  output logic [VEC_W-1:0] vec_o
);
  logic             pend_q, pend_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             claim;

  // while a winner is locked only that slot claims, else any pending slot does
  always_comb begin
    claim   = hold_i ? won_i : pend_q;
    grant_o = ack_in & claim;
    ack_out = ack_in & ~claim;
    vec_o   = grant_o ? vec_q : '0;
    pend_o  = pend_q;
  end

  // a fresh request outranks the self-clear
  always_comb begin
    pend_d = set_i | (pend_q & ~(clr_i & won_i));
    vec_d  = cfg_we_i ? cfg_vec_i : vec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      vec_q  <= RST_VEC;
    end else begin
      pend_q <= pend_d;
      if (cfg_we_i) vec_q <= vec_d;
    end
  end
endmodule

// File: rtl/vecack_merge.sv
module vecack_merge #(
  parameter int unsigned N_SLOTS = 4,
  parameter int unsigned VEC_W   = 8
) (
  input  logic [N_SLOTS-1:0][VEC_W-1:0] vec_i,
  input  logic [N_SLOTS-1:0]            grant_i,
  output logic [VEC_W-1:0]              vec_o,
  output logic                          valid_o
);
  always_comb begin
    vec_o = '0;
    for (int i = 0; i < int'(N_SLOTS); i++) vec_o = vec_o | vec_i[i];
    valid_o = |grant_i;
  end
endmodule

// File: rtl/vecack_chain.sv
module vecack_chain
  import vecack_pkg::*;
#(
  parameter int unsigned N_SLOTS      = DEF_SLOTS,
  parameter int unsigned VEC_W        = DEF_VEC_W,
  parameter logic [VEC_W-1:0] RST_VEC_BASE = 8'h40,
  localparam int unsigned SEL_W       = sel_width(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SLOTS-1:0] req_set,
  input  logic               cfg_we,
  input  logic [SEL_W-1:0]   cfg_sel,
  input  logic [VEC_W-1:0]   cfg_vec,
  input  logic               iack_in,
  output logic               irq_out,
  output logic [VEC_W-1:0]   vec_out,
  output logic               vec_valid,
  output logic               ack_tail
);
  logic [N_SLOTS:0]                ack_w;
  logic [N_SLOTS-1:0]              grant, pend;
  logic [N_SLOTS-1:0][VEC_W-1:0]   vec_w;
  logic [N_SLOTS-1:0]              win_q, win_d;
  logic                            busy_q, busy_d;
  logic                            clr_w;

  assign ack_w[0] = iack_in;
  assign clr_w    = busy_q & ~iack_in;

  for (genvar g = 0; g < int'(N_SLOTS); g++) begin : g_slot
    vecack_slot #(
      .VEC_W  (VEC_W),
      .RST_VEC(RST_VEC_BASE + VEC_W'(g))
    ) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (req_set[g]),
      .clr_i    (clr_w),
      .hold_i   (busy_q),
      .won_i    (win_q[g]),
      .cfg_we_i (cfg_we && (cfg_sel == SEL_W'(g))),
      .cfg_vec_i(cfg_vec),
      .ack_in   (ack_w[g]),
      .ack_out  (ack_w[g+1]),
      .grant_o  (grant[g]),
      .pend_o   (pend[g]),
      .vec_o    (vec_w[g])
    );
  end

  vecack_merge #(.N_SLOTS(N_SLOTS), .VEC_W(VEC_W)) merge_i (
    .vec_i  (vec_w),
    .grant_i(grant),
    .vec_o  (vec_out),
    .valid_o(vec_valid)
  );

  assign irq_out  = |pend;
  assign ack_tail = ack_w[N_SLOTS];

  // lock the winner on the first acknowledged cycle, release when acknowledge drops
  always_comb begin
    busy_d = busy_q;
    win_d  = win_q;
    if (!iack_in) begin
      busy_d = 1'b0;
      win_d  = '0;
    end else if (!busy_q) begin
      busy_d = |grant;
      win_d  = grant;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      win_q  <= '0;
    end else begin
      busy_q <= busy_d;
      win_q  <= win_d;
    end
  end
endmodule

// File: rtl/vecack_chain_chk.sv
module vecack_chain_chk #(
  parameter int unsigned N_SLOTS = 4,
  parameter int unsigned VEC_W   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               iack_in,
  input logic               irq_out,
  input logic [VEC_W-1:0]   vec_out,
  input logic               vec_valid,
  input logic               ack_tail,
  input logic [N_SLOTS-1:0] grant
);
  assert_idle_bus_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !iack_in |-> (!vec_valid && vec_out == '0));

  assert_single_winner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_tail_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && ack_tail));

  assert_winner_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> irq_out);

  assert_hold_vector_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_in && $past(iack_in) && $past(vec_valid)) |-> (vec_valid && $stable(vec_out)));
endmodule

bind vecack_chain vecack_chain_chk #(.N_SLOTS(N_SLOTS), .VEC_W(VEC_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .iack_in  (iack_in),
  .irq_out  (irq_out),
  .vec_out  (vec_out),
  .vec_valid(vec_valid),
  .ack_tail (ack_tail),
  .grant    (grant)
);

// File: tb/vecack_chain_tb.sv
module vecack_chain_tb_top;
  localparam int N = 4;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] req_set;
  logic         cfg_we;
  logic [1:0]   cfg_sel;
  logic [W-1:0] cfg_vec;
  logic         iack_in;
  logic         irq_out, vec_valid, ack_tail;
  logic [W-1:0] vec_out;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] model;
  logic [W-1:0] vexp [N];

  always #4 clk = ~clk;

  vecack_chain dut_i (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_vec(cfg_vec), .iack_in(iack_in),
    .irq_out(irq_out), .vec_out(vec_out), .vec_valid(vec_valid), .ack_tail(ack_tail)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int lowest(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  // one full acknowledge: raise, check, hold, drop
  task automatic serve(input string req);
    int w;
    w = lowest(model);
    iack_in = 1'b1;
    #2;
    chk({req, " valid"}, 32'(vec_valid), 32'(w >= 0));
    chk({req, " vec"}, 32'(vec_out), (w >= 0) ? 32'(vexp[w]) : 32'h0);
    chk({req, " R5 tail"}, 32'(ack_tail), 32'(w < 0));
    step();
    #2;
    chk("R10 held vec", 32'(vec_out), (w >= 0) ? 32'(vexp[w]) : 32'h0);
    step();
    iack_in = 1'b0;
    #2;
    chk("R4 idle valid", 32'(vec_valid), 32'h0);
    chk("R4 idle vec", 32'(vec_out), 32'h0);
    step();
    if (w >= 0) model[w] = 1'b0;
    #2;
    chk("R6 irq after clear", 32'(irq_out), 32'(model != '0));
  endtask

  initial begin
    rst_n = 1'b0; req_set = '0; cfg_we = 1'b0; cfg_sel = '0; cfg_vec = '0; iack_in = 1'b0;
    model = '0;
    for (int i = 0; i < N; i++) vexp[i] = W'(8'h40 + i);
    repeat (3) step();
    rst_n = 1'b1;
    #2;
    chk("R1 irq", 32'(irq_out), 32'h0);
    chk("R1 valid", 32'(vec_valid), 32'h0);
    chk("R1 tail", 32'(ack_tail), 32'h0);
    chk("R1 vec", 32'(vec_out), 32'h0);
    step();

    // R1 reset vectors: serve each slot alone
    for (int i = 0; i < N; i++) begin
      req_set = N'(1 << i); step(); req_set = '0; model = N'(1 << i);
      #2; chk("R2 irq set", 32'(irq_out), 32'h1);
      serve("R1 reset vector");
    end

    // R5 acknowledge with nothing pending
    serve("R5 empty ack");

    // R8 program distinct vectors
    for (int i = 0; i < N; i++) begin
      cfg_we = 1'b1; cfg_sel = 2'(i); cfg_vec = W'(8'hA0 + 8'h13 * i);
      vexp[i] = cfg_vec;
      step();
    end
    cfg_we = 1'b0;

    // R3 exhaustive pending sets drained in priority order
    for (int m = 1; m < (1 << N); m++) begin
      req_set = N'(m); step(); req_set = '0; model = N'(m);
      #2; chk("R2 irq any", 32'(irq_out), 32'h1);
      while (model != '0) serve("R3 priority");
    end

    // R7 late request nearer the processor does not preempt
    req_set = 4'b0100; step(); req_set = '0; model = 4'b0100;
    iack_in = 1'b1; #2;
    chk("R7 first winner", 32'(vec_out), 32'(vexp[2]));
    req_set = 4'b0001; step(); req_set = '0; model = 4'b0101;
    #2; chk("R7 no preempt", 32'(vec_out), 32'(vexp[2]));
    step(); #2; chk("R7 still held", 32'(vec_out), 32'(vexp[2]));
    iack_in = 1'b0; step(); model = 4'b0001;
    serve("R7 late request served");

    // R9 set on the clearing edge keeps the slot pending
    req_set = 4'b1000; step(); req_set = '0; model = 4'b1000;
    iack_in = 1'b1; #2;
    chk("R9 winner", 32'(vec_out), 32'(vexp[3]));
    step();
    iack_in = 1'b0; req_set = 4'b1000; step(); req_set = '0;
    #2; chk("R9 still pending", 32'(irq_out), 32'h1);
    serve("R9 reserved");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule